// File: doc/BRIEF.md
# Indirect Jump Translation Cache

This block sits beside the fetch unit of a processor that runs translated code out of a code cache. When an indirect jump executes, the jump's register operand supplies a target address in the original program. The block translates that address into the matching code-cache address. It also judges the branch target buffer's guess for the next fetch address.

Every lookup produces one of three verdicts. The guess was right and no redirect is needed. The guess was wrong and fetch must go to the translated address held in the table. Or the table has no entry, and fetch must go to a software dispatch routine.

The table is direct-mapped and only software fills it. Software installs pairs through a write port, sets the dispatch routine address through a configuration write, and can wipe every entry with a single invalidate command. A miss never installs anything. Software decides what the table holds.

Top module: `ijump_xlate_cache`

## Requirements
- R1: After reset the table holds no valid entry, the dispatch address is 0, and res_valid, res_correct, res_redirect and res_miss are all 0. A lookup made right after reset reports a miss with res_target 0.
- R2: A lookup is accepted in every cycle where lk_valid is 1. Its result appears with res_valid 1 in the next cycle. In a cycle that follows no lookup, res_valid and all three verdict outputs are 0.
- R3: While res_valid is 1, exactly one of res_correct, res_redirect and res_miss is 1.
- R4: On a hit whose stored translated address equals lk_pred_addr, res_correct is 1 and res_target equals that predicted address.
- R5: On a hit whose stored translated address differs from lk_pred_addr, res_redirect is 1 and res_target is the stored translated address.
- R6: On a miss, res_miss is 1 and res_target is the current dispatch address.
- R7: Source address bits [7:2] select one of 64 entries and bits [31:8] are stored and compared as the tag. Bits [1:0] take no part. A write to an index replaces whatever entry was there, so a different tag at the same index then misses.
- R8: When a table write and a lookup occur in the same cycle, the lookup sees the table as it was before the write. The write is visible from the next cycle on.
- R9: inv_all clears every entry in one cycle. A lookup in the same cycle still sees the old contents. A write in the same cycle as inv_all is applied after the clear and remains valid.
- R10: cfg_we loads cfg_dispatch_addr as the dispatch address. A lookup in the same cycle uses the previous dispatch address.
- R11: A lookup that misses leaves the table unchanged, so repeating it misses again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| lk_valid | input | 1 | Lookup request strobe |
| lk_src_addr | input | 32 | Source-program target address of the indirect jump |
| lk_pred_addr | input | 32 | Predicted next fetch address from the branch target buffer |
| wr_en | input | 1 | Install an entry |
| wr_src_addr | input | 32 | Source address of the entry being installed |
| wr_tgt_addr | input | 32 | Translated code-cache address of the entry |
| cfg_we | input | 1 | Write the dispatch routine address |
| cfg_dispatch_addr | input | 32 | New dispatch routine address |
| inv_all | input | 1 | Invalidate every entry |
| res_valid | output | 1 | Result present for the lookup of the previous cycle |
| res_correct | output | 1 | Prediction confirmed |
| res_redirect | output | 1 | Prediction wrong, redirect to res_target |
| res_miss | output | 1 | No entry, redirect to the dispatch routine |
| res_target | output | 32 | Fetch address that goes with the verdict |

## Verification
The hardest cases to reach are the same-cycle collisions. In one, a lookup meets a write that overwrites the very entry it is reading. In another, it meets an invalidate, or a dispatch-address update. The stimulus drives each pair of commands in a single cycle and follows at once with a second lookup. That way the old view and the new view are both observed at the ports. Index aliasing is reached with two source addresses that share bits [7:2] but differ above them, and with addresses that differ only in bits [1:0].

// File: rtl/ijx_pkg.sv
package ijx_pkg;

    typedef enum logic [1:0] {
        VERD_NONE     = 2'd0,
        VERD_CORRECT  = 2'd1,
        VERD_REDIRECT = 2'd2,
        VERD_MISS     = 2'd3
    } verdict_e;

endpackage

// File: rtl/ijx_store.sv
module ijx_store #(
    parameter int ENTRIES = 64,
    parameter int TAG_W   = 24,
    parameter int TGT_W   = 32,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [TAG_W-1:0] wr_tag,
    input  logic [TGT_W-1:0] wr_tgt,
    input  logic             inv_all,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_valid,
    output logic [TAG_W-1:0] rd_tag,
    output logic [TGT_W-1:0] rd_tgt
);

    logic [ENTRIES-1:0] valid_d, valid_q;
    logic [TAG_W-1:0]   tag_q [ENTRIES];
    logic [TGT_W-1:0]   tgt_q [ENTRIES];

    // Clear first, then install: a write beside inv_all survives.
    always_comb begin
        valid_d = valid_q;
        if (inv_all) valid_d = '0;
        if (wr_en)   valid_d[wr_idx] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) valid_q <= '0;
        else        valid_q <= valid_d;
    end

    // Payload needs no reset; the valid bit guards it.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_q[wr_idx] <= wr_tag;
            tgt_q[wr_idx] <= wr_tgt;
        end
    end

    // Read of the current state: a write this cycle is not yet seen.
    assign rd_valid = valid_q[rd_idx];
    assign rd_tag   = tag_q[rd_idx];
    assign rd_tgt   = tgt_q[rd_idx];

endmodule

// File: rtl/ijx_resolve.sv
module ijx_resolve
    import ijx_pkg::*;
#(
    parameter int TAG_W = 24,
    parameter int TGT_W = 32
) (
    input  logic             ent_valid,
    input  logic [TAG_W-1:0] ent_tag,
    input  logic [TGT_W-1:0] ent_tgt,
    input  logic [TAG_W-1:0] req_tag,
    input  logic [TGT_W-1:0] pred_addr,
    input  logic [TGT_W-1:0] dispatch_addr,
    output verdict_e         verdict,
    output logic [TGT_W-1:0] target
);

    logic hit;

    always_comb begin
        hit = ent_valid && (ent_tag == req_tag);
        if (!hit) begin
            verdict = VERD_MISS;
            target  = dispatch_addr;
        end else if (ent_tgt == pred_addr) begin
            verdict = VERD_CORRECT;
            target  = pred_addr;
        end else begin
            verdict = VERD_REDIRECT;
            target  = ent_tgt;
        end
    end

endmodule

// File: rtl/ijump_xlate_cache.sv
module ijump_xlate_cache
    import ijx_pkg::*;
#(
    parameter int SRC_W    = 32,
    parameter int TGT_W    = 32,
    parameter int ENTRIES  = 64,
    parameter int BYTE_OFS = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lk_valid,
    input  logic [SRC_W-1:0] lk_src_addr,
    input  logic [TGT_W-1:0] lk_pred_addr,
    input  logic             wr_en,
    input  logic [SRC_W-1:0] wr_src_addr,
    input  logic [TGT_W-1:0] wr_tgt_addr,
    input  logic             cfg_we,
    input  logic [TGT_W-1:0] cfg_dispatch_addr,
    input  logic             inv_all,
    output logic             res_valid,
    output logic             res_correct,
    output logic             res_redirect,
    output logic             res_miss,
    output logic [TGT_W-1:0] res_target
);

    localparam int IDX_W = $clog2(ENTRIES);
    localparam int IDX_LO = BYTE_OFS;
    localparam int TAG_LO = BYTE_OFS + IDX_W;
    localparam int TAG_W  = SRC_W - TAG_LO;

    typedef struct packed {
        logic             valid;
        verdict_e         verdict;
        logic [TGT_W-1:0] target;
        logic [TGT_W-1:0] dispatch;
    } state_t;

    state_t state_d, state_q;

    logic             ent_valid;
    logic [TAG_W-1:0] ent_tag;
    logic [TGT_W-1:0] ent_tgt;
    verdict_e         rv_verdict;
    logic [TGT_W-1:0] rv_target;

    logic unused_ofs;
    assign unused_ofs = ^{lk_src_addr[IDX_LO-1:0], wr_src_addr[IDX_LO-1:0]};

    ijx_store #(
        .ENTRIES (ENTRIES),
        .TAG_W   (TAG_W),
        .TGT_W   (TGT_W)
    ) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_idx   (wr_src_addr[TAG_LO-1:IDX_LO]),
        .wr_tag   (wr_src_addr[SRC_W-1:TAG_LO]),
        .wr_tgt   (wr_tgt_addr),
        .inv_all  (inv_all),
        .rd_idx   (lk_src_addr[TAG_LO-1:IDX_LO]),
        .rd_valid (ent_valid),
        .rd_tag   (ent_tag),
        .rd_tgt   (ent_tgt)
    );

    ijx_resolve #(
        .TAG_W (TAG_W),
        .TGT_W (TGT_W)
    ) u_resolve (
        .ent_valid     (ent_valid),
        .ent_tag       (ent_tag),
        .ent_tgt       (ent_tgt),
        .req_tag       (lk_src_addr[SRC_W-1:TAG_LO]),
        .pred_addr     (lk_pred_addr),
        .dispatch_addr (state_q.dispatch),
        .verdict       (rv_verdict),
        .target        (rv_target)
    );

    always_comb begin
        state_d          = state_q;
        state_d.valid    = lk_valid;
        state_d.verdict  = lk_valid ? rv_verdict : VERD_NONE;
        state_d.target   = lk_valid ? rv_target : '0;
        if (cfg_we) state_d.dispatch = cfg_dispatch_addr;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q.valid    <= 1'b0;
            state_q.verdict  <= VERD_NONE;
            state_q.target   <= '0;
            state_q.dispatch <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign res_valid    = state_q.valid;
    assign res_correct  = state_q.verdict == VERD_CORRECT;
    assign res_redirect = state_q.verdict == VERD_REDIRECT;
    assign res_miss     = state_q.verdict == VERD_MISS;
    assign res_target   = state_q.target;

endmodule

// File: rtl/ijx_checker.sv
module ijx_checker #(
    parameter int TGT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             lk_valid,
    input logic [TGT_W-1:0] lk_pred_addr,
    input logic             wr_en,
    input logic             inv_all,
    input logic             res_valid,
    input logic             res_correct,
    input logic             res_redirect,
    input logic             res_miss,
    input logic [TGT_W-1:0] res_target
);

    p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> res_valid);

    p_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |=> (!res_valid && !res_correct && !res_redirect && !res_miss));

    p_one_verdict_r3: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> ($countones({res_correct, res_redirect, res_miss}) == 1));

    p_confirm_target_r4: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> (res_correct -> (res_target == $past(lk_pred_addr))));

    p_redirect_differs_r5: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> (res_redirect -> (res_target != $past(lk_pred_addr))));

    p_cleared_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (inv_all && !wr_en) ##1 lk_valid |=> res_miss);

endmodule

bind ijump_xlate_cache ijx_checker #(.TGT_W(TGT_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .lk_valid     (lk_valid),
    .lk_pred_addr (lk_pred_addr),
    .wr_en        (wr_en),
    .inv_all      (inv_all),
    .res_valid    (res_valid),
    .res_correct  (res_correct),
    .res_redirect (res_redirect),
    .res_miss     (res_miss),
    .res_target   (res_target)
);

// File: tb/ijump_xlate_cache_tb.sv
`timescale 1ns/1ps
module ijump_xlate_cache_tb;

    localparam int K_CORRECT  = 0;
    localparam int K_REDIRECT = 1;
    localparam int K_MISS     = 2;

    typedef struct {
        int          kind;
        logic [31:0] tgt;
        string       req;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lk_valid = 1'b0;
    logic [31:0] lk_src_addr = '0;
    logic [31:0] lk_pred_addr = '0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_src_addr = '0;
    logic [31:0] wr_tgt_addr = '0;
    logic        cfg_we = 1'b0;
    logic [31:0] cfg_dispatch_addr = '0;
    logic        inv_all = 1'b0;
    logic        res_valid, res_correct, res_redirect, res_miss;
    logic [31:0] res_target;

    int   n_checks = 0;
    int   n_fails  = 0;
    exp_t sb[$];
    bit   done = 1'b0;

    always #2 clk = ~clk;

    ijump_xlate_cache u_dut (
        .clk               (clk),
        .rst_n             (rst_n),
        .lk_valid          (lk_valid),
        .lk_src_addr       (lk_src_addr),
        .lk_pred_addr      (lk_pred_addr),
        .wr_en             (wr_en),
        .wr_src_addr       (wr_src_addr),
        .wr_tgt_addr       (wr_tgt_addr),
        .cfg_we            (cfg_we),
        .cfg_dispatch_addr (cfg_dispatch_addr),
        .inv_all           (inv_all),
        .res_valid         (res_valid),
        .res_correct       (res_correct),
        .res_redirect      (res_redirect),
        .res_miss          (res_miss),
        .res_target        (res_target)
    );

    task automatic tick();
        @(negedge clk);
        lk_valid = 1'b0;
        wr_en    = 1'b0;
        cfg_we   = 1'b0;
        inv_all  = 1'b0;
    endtask

    task automatic put(input logic [31:0] src, input logic [31:0] tgt);
        wr_en       = 1'b1;
        wr_src_addr = src;
        wr_tgt_addr = tgt;
    endtask

    task automatic ask(input logic [31:0] src, input logic [31:0] pred,
                       input int kind, input logic [31:0] tgt, input string req);
        exp_t e;
        lk_valid     = 1'b1;
        lk_src_addr  = src;
        lk_pred_addr = pred;
        e.kind = kind;
        e.tgt  = tgt;
        e.req  = req;
        sb.push_back(e);
    endtask

    function automatic int seen_kind();
        if ({res_correct, res_redirect, res_miss} == 3'b100) return K_CORRECT;
        if ({res_correct, res_redirect, res_miss} == 3'b010) return K_REDIRECT;
        if ({res_correct, res_redirect, res_miss} == 3'b001) return K_MISS;
        return -1;
    endfunction

    // Monitor: compare each produced result with the oldest expectation.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (res_valid) begin
                n_checks++;
                if (sb.size() == 0) begin
                    n_fails++;
                    $display("FAIL R2: unexpected result, actual kind=%0d expected none", seen_kind());
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    if (seen_kind() != e.kind || res_target !== e.tgt) begin
                        n_fails++;
                        $display("FAIL %s: actual kind=%0d target=%h expected kind=%0d target=%h",
                                 e.req, seen_kind(), res_target, e.kind, e.tgt);
                    end
                end
            end else if (res_correct || res_redirect || res_miss) begin
                n_checks++;
                n_fails++;
                $display("FAIL R2: verdict without res_valid, actual %b%b%b expected 000",
                         res_correct, res_redirect, res_miss);
            end
        end
    end

    initial begin
        #(200000 * 4);
        n_fails++;
        $display("FAIL watchdog: actual run still busy expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        n_checks++;
        if (res_valid || res_correct || res_redirect || res_miss || res_target !== 32'h0) begin
            n_fails++;
            $display("FAIL R1: reset outputs actual %b%b%b%b %h expected 0000 0",
                     res_valid, res_correct, res_redirect, res_miss, res_target);
        end
        rst_n = 1'b1;
        tick();

        // R1/R6: empty table, dispatch address still 0
        ask(32'h1000_0040, 32'h0, K_MISS, 32'h0, "R1");
        tick();
        cfg_we = 1'b1; cfg_dispatch_addr = 32'h0000_F000;
        tick();
        ask(32'h1000_0040, 32'h0, K_MISS, 32'h0000_F000, "R6");
        tick();

        // R4/R5/R7: install A, confirm, mispredict, low bits ignored
        put(32'h1000_0040, 32'h0000_9AC0);
        tick();
        ask(32'h1000_0040, 32'h0000_9AC0, K_CORRECT, 32'h0000_9AC0, "R4");
        tick();
        ask(32'h1000_0040, 32'h0000_1234, K_REDIRECT, 32'h0000_9AC0, "R5");
        tick();
        ask(32'h1000_0043, 32'h0000_9AC0, K_CORRECT, 32'h0000_9AC0, "R7");
        tick();

        // R7: alias B shares index bits [7:2], different tag
        ask(32'h2000_0040, 32'h0, K_MISS, 32'h0000_F000, "R7");
        tick();
        put(32'h2000_0040, 32'h0000_B000);
        tick();
        ask(32'h1000_0040, 32'h0000_9AC0, K_MISS, 32'h0000_F000, "R7");
        tick();
        ask(32'h2000_0040, 32'h0, K_REDIRECT, 32'h0000_B000, "R7");
        tick();

        // R8: write A over B while looking up B in the same cycle
        put(32'h1000_0040, 32'h0000_A100);
        ask(32'h2000_0040, 32'h0000_B000, K_CORRECT, 32'h0000_B000, "R8");
        tick();
        ask(32'h1000_0040, 32'h0000_A100, K_CORRECT, 32'h0000_A100, "R8");
        tick();

        // R10: dispatch update beside a missing lookup
        cfg_we = 1'b1; cfg_dispatch_addr = 32'h0000_E000;
        ask(32'h3000_0080, 32'h0, K_MISS, 32'h0000_F000, "R10");
        tick();
        // R11: the miss installed nothing
        ask(32'h3000_0080, 32'h0, K_MISS, 32'h0000_E000, "R11");
        tick();

        // R9: invalidate beside a lookup, then beside a write
        put(32'h3000_0084, 32'h0000_D000);
        tick();
        inv_all = 1'b1;
        ask(32'h1000_0040, 32'h0000_A100, K_CORRECT, 32'h0000_A100, "R9");
        tick();
        ask(32'h1000_0040, 32'h0, K_MISS, 32'h0000_E000, "R9");
        tick();
        inv_all = 1'b1;
        put(32'h4000_0100, 32'h0000_E500);
        tick();
        ask(32'h4000_0100, 32'h0000_E500, K_CORRECT, 32'h0000_E500, "R9");
        tick();
        ask(32'h3000_0084, 32'h0, K_MISS, 32'h0000_E000, "R9");
        tick();

        // R4/R7: several indices held at once, back-to-back lookups
        for (int i = 1; i <= 8; i++) begin
            put(32'h5000_0000 | (i << 2), 32'h0000_8000 + i * 16);
            tick();
        end
        for (int i = 1; i <= 8; i++) begin
            ask(32'h5000_0000 | (i << 2), 32'h0000_8000 + i * 16, K_CORRECT,
                32'h0000_8000 + i * 16, "R4");
            tick();
        end
        for (int i = 1; i <= 8; i++) begin
            ask(32'h5000_0000 | (i << 2), 32'h0, K_REDIRECT, 32'h0000_8000 + i * 16, "R5");
            tick();
        end

        repeat (3) tick();
        done = 1'b1;
        n_checks++;
        if (sb.size() != 0) begin
            n_fails++;
            $display("FAIL R2: results missing, actual pending=%0d expected 0", sb.size());
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule